// File: doc/BRIEF.md
# Performance Counter Bank with Sign-Threshold Alert

This block holds six 32-bit event counters and one 64-bit mode register. Each counter adds one on every cycle its increment input is high, unless freeze bits in the mode register stop it. One freeze bit stops every counter. Two group bits each stop one half of the bank: counters 1 to 4, or counters 5 and 6.

A counter whose event select says it counts cycles can raise a monitor alert when its value enters the negative range, which means bit 31 is set. Counter 1 has its own condition-enable bit. Counters 2 to 6 share a second one, and counter 5 can never raise this alert. The alert is kept as a sticky bit inside the mode register. If the exception-enable bit is set when the alert first rises, a one-cycle exception request is also issued.

Software reaches the mode register and the counters through a plain write port and a combinational read port. The only data-like inputs are the increment strobes, sampled once per cycle. They carry no handshake, so the block never applies back-pressure and never drops a strobe.

Top module: `pmu_bank`

## Requirements
- R1: After reset the mode register, all six counters, `alert` and `exc_req` read zero.
- R2: Address 0 selects the mode register and addresses 1 to 6 select counters 1 to 6. A counter write keeps the low 32 bits of the write data. A counter reads back zero-extended to 64 bits. Reads of address 7 return zero.
- R3: An unfrozen counter adds one on each clock edge where its increment bit is high, and wraps from 0xFFFFFFFF to 0.
- R4: Mode bit 31 freezes all counters. Bit 5 freezes counters 1 to 4. Bit 4 freezes counters 5 and 6. A frozen counter holds its value.
- R5: A register write to a counter takes priority over an increment in the same cycle.
- R6: A counter that is unfrozen, whose event select bit is high and whose condition enable is set, with bit 31 of its value set, sets `alert` and mode bit 7 one cycle later. Counter 1 uses enable bit 15; counters 2 to 6 use enable bit 14.
- R7: No alert is raised for a counter whose event select is low, whose condition enable is clear, or which is frozen.
- R8: Counter 5 never raises an alert.
- R9: The alert stays set until the mode register is written with bit 7 clear. If the condition still holds after that write, the alert is set again one cycle later.
- R10: `exc_req` is high for exactly one cycle, in the same cycle the alert rises from clear, and only while mode bit 20 is set.
- R11: Writing a counter with a value at or above 0x80000000 while its alert is armed raises the alert in the next cycle.
- R12: A counter that counts up across 0x7FFFFFFF into 0x80000000 while armed raises the alert one cycle after it reaches 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address (0 mode, 1-6 counters) |
| reg_wdata | input | 64 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Read data, combinational |
| cnt_inc | input | 6 | Per-counter increment strobes |
| evt_cyc | input | 6 | Per-counter select: high when the counter counts cycles |
| alert | output | 1 | Sticky monitor alert |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The assertions assume that every input is driven to a known value and held steady around each rising edge, and that write data is valid whenever `reg_wr` is high. The bench meets this by changing all inputs only on falling edges. It keeps the increment and event-select inputs at zero, except in the tests that need them. That way no alert appears by accident while freeze or priority behaviour is being checked.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // Mode register bit positions (little-endian numbering)
  localparam int MODE_W     = 64;
  localparam int FRZ_ALL    = 31;
  localparam int FRZ_LOW    = 5;   // counters 1..4
  localparam int FRZ_HIGH   = 4;   // counters 5..6
  localparam int CE_FIRST   = 15;  // counter 1 condition enable
  localparam int CE_OTHERS  = 14;  // counters 2..N condition enable
  localparam int EXC_EN     = 20;
  localparam int ALERT_BIT  = 7;
  // Bank layout
  localparam int LOW_GROUP  = 4;   // counters with index below this use FRZ_LOW
  localparam int NO_ARM_IDX = 4;   // zero-based index of the counter that never alerts
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CW      = 32,
  parameter bit HAS_ARM = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wr_data,
  input  logic          inc,
  input  logic          frz,
  input  logic          arm,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (wr)         cnt_q <= wr_data;
    else if (inc && !frz) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  generate
    if (HAS_ARM) begin : g_arm
      assign hit = arm && !frz && cnt_q[CW-1];
    end else begin : g_noarm
      assign hit = 1'b0;
    end
  endgenerate

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !wr) |=> (cnt_q == $past(cnt_q)));                         // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wr_data)));                                  // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !frz && !wr) |=> (cnt_q == $past(cnt_q) + 1'b1));           // R3
endmodule

// File: rtl/pmu_mode_reg.sv
module pmu_mode_reg
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              hit_any,
  output logic [MODE_W-1:0] mode,
  output logic              exc_req
);
  logic [MODE_W-1:0] mode_q;
  logic              exc_q;
  logic              rise;

  assign rise = hit_any && !wr && !mode_q[ALERT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      if (wr)           mode_q <= wr_data;
      else if (hit_any) mode_q[ALERT_BIT] <= 1'b1;
      exc_q <= rise && mode_q[EXC_EN];
    end
  end

  assign mode    = mode_q;
  assign exc_req = exc_q;

  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[ALERT_BIT] && !wr) |=> mode_q[ALERT_BIT]);                  // R9
  AST_EXC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> (mode_q[EXC_EN] && mode_q[ALERT_BIT]));                   // R10
  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |=> !exc_q);                                                  // R10
  AST_ALERT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[ALERT_BIT] && !hit_any && !wr) |=> !mode_q[ALERT_BIT]);    // R7
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int NCNT   = 6,
  parameter int CW     = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [MODE_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MODE_W-1:0] rd_data,
  input  logic [NCNT-1:0]   cnt_inc,
  input  logic [NCNT-1:0]   evt_cyc,
  output logic              alert,
  output logic              exc_req
);
  logic [MODE_W-1:0] mode;
  logic [CW-1:0]     cnt_v [NCNT];
  logic [NCNT-1:0]   hit_v;
  logic [NCNT-1:0]   frz_v;
  logic [NCNT-1:0]   arm_v;
  logic [NCNT-1:0]   wr_v;
  logic              wr_mode;

  assign wr_mode = reg_wr && (reg_addr == '0);

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam bit LOW = (i < LOW_GROUP);
    localparam bit ARMABLE = (i != NO_ARM_IDX);
    logic ce;

    assign wr_v[i]  = reg_wr && (reg_addr == ADDR_W'(i + 1));
    assign frz_v[i] = mode[FRZ_ALL] || (LOW ? mode[FRZ_LOW] : mode[FRZ_HIGH]);
    assign ce       = (i == 0) ? mode[CE_FIRST] : mode[CE_OTHERS];
    assign arm_v[i] = evt_cyc[i] && ce;

    pmu_counter #(.CW(CW), .HAS_ARM(ARMABLE)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_v[i]),
      .wr_data (reg_wdata[CW-1:0]),
      .inc     (cnt_inc[i]),
      .frz     (frz_v[i]),
      .arm     (arm_v[i]),
      .cnt     (cnt_v[i]),
      .hit     (hit_v[i])
    );
  end

  pmu_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_mode),
    .wr_data (reg_wdata),
    .hit_any (|hit_v),
    .mode    (mode),
    .exc_req (exc_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = mode;
    for (int i = 0; i < NCNT; i++)
      if (rd_addr == ADDR_W'(i + 1)) rd_data = MODE_W'(cnt_v[i]);
  end

  assign alert = mode[ALERT_BIT];

  AST_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode == $past(reg_wdata)));                            // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mode, wr_v}));                                         // R2
endmodule

// File: tb/pmu_bank_tb.sv
`timescale 1ns/1ps
module pmu_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [5:0]  cnt_inc = '0;
  logic [5:0]  evt_cyc = '0;
  logic        alert;
  logic        exc_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] M_FRZ_ALL = 64'h1 << 31;
  localparam logic [63:0] M_FRZ_LOW = 64'h1 << 5;
  localparam logic [63:0] M_FRZ_HI  = 64'h1 << 4;
  localparam logic [63:0] M_CE1     = 64'h1 << 15;
  localparam logic [63:0] M_CEN     = 64'h1 << 14;
  localparam logic [63:0] M_EXC     = 64'h1 << 20;

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] start;
    logic [7:0]  n;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd1, 32'h0000_0000, 8'd5,  32'h0000_0005},
    '{3'd2, 32'h0000_00FF, 8'd1,  32'h0000_0100},
    '{3'd3, 32'hFFFF_FFFE, 8'd3,  32'h0000_0001},
    '{3'd4, 32'h7FFF_FFFF, 8'd2,  32'h8000_0001},
    '{3'd5, 32'h1234_5678, 8'd0,  32'h1234_5678},
    '{3'd6, 32'hFFFF_FFFF, 8'd1,  32'h0000_0000}
  };

  pmu_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_inc(cnt_inc), .evt_cyc(evt_cyc), .alert(alert), .exc_req(exc_req)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clear_all();
    wr_reg(3'd0, 64'h0);
    for (int i = 1; i <= 6; i++) wr_reg(3'(i), 64'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %h expected %h", 64'h0, 64'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i <= 6; i++) begin
      rd_reg(3'(i), d);
      chk(d == 64'h0, "R1 reset value", d, 64'h0);
    end
    chk(alert == 1'b0, "R1 alert", 64'(alert), 64'h0);
    chk(exc_req == 1'b0, "R1 exc_req", 64'(exc_req), 64'h0);

    // R3: vector table of counting runs (R3 wrap included)
    foreach (VEC[k]) begin
      wr_reg(VEC[k].idx, 64'(VEC[k].start));
      if (VEC[k].n != 0) begin
        cnt_inc[VEC[k].idx - 1] = 1'b1;
        repeat (VEC[k].n) @(negedge clk);
        cnt_inc = '0;
      end
      rd_reg(VEC[k].idx, d);
      chk(d == 64'(VEC[k].exp), "R3 count table", d, 64'(VEC[k].exp));
    end
    chk(alert == 1'b0, "R7 no alert without select", 64'(alert), 64'h0);

    // R2: truncation, mode readback, unmapped address
    wr_reg(3'd2, 64'hFFFF_FFFF_1234_5678);
    rd_reg(3'd2, d);
    chk(d == 64'h1234_5678, "R2 truncate", d, 64'h1234_5678);
    wr_reg(3'd0, 64'hA000_0000_0000_0100);
    rd_reg(3'd0, d);
    chk(d == 64'hA000_0000_0000_0100, "R2 mode readback", d, 64'hA000_0000_0000_0100);
    rd_reg(3'd7, d);
    chk(d == 64'h0, "R2 unmapped", d, 64'h0);

    // R4: freeze groups
    clear_all();
    wr_reg(3'd0, M_FRZ_LOW);
    cnt_inc = 6'h3F; repeat (3) @(negedge clk); cnt_inc = '0;
    for (int i = 1; i <= 6; i++) begin
      rd_reg(3'(i), d);
      chk(d == ((i <= 4) ? 64'h0 : 64'h3), "R4 low group freeze", d, (i <= 4) ? 64'h0 : 64'h3);
    end
    wr_reg(3'd0, M_FRZ_HI);
    cnt_inc = 6'h3F; repeat (2) @(negedge clk); cnt_inc = '0;
    rd_reg(3'd1, d); chk(d == 64'h2, "R4 high freeze c1", d, 64'h2);
    rd_reg(3'd6, d); chk(d == 64'h3, "R4 high freeze c6", d, 64'h3);
    wr_reg(3'd0, M_FRZ_ALL);
    cnt_inc = 6'h3F; repeat (2) @(negedge clk); cnt_inc = '0;
    rd_reg(3'd1, d); chk(d == 64'h2, "R4 global freeze c1", d, 64'h2);
    rd_reg(3'd5, d); chk(d == 64'h3, "R4 global freeze c5", d, 64'h3);

    // R5: write beats increment
    wr_reg(3'd0, 64'h0);
    @(negedge clk);
    cnt_inc[0] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 64'd100;
    @(negedge clk);
    reg_wr = 1'b0; cnt_inc = '0;
    rd_reg(3'd1, d);
    chk(d == 64'd100, "R5 write priority", d, 64'd100);

    // R11 / R6: write at threshold, counter 1 own enable
    clear_all();
    wr_reg(3'd0, M_CE1);
    evt_cyc[0] = 1'b1;
    wr_reg(3'd1, 64'h8000_0000);
    chk(alert == 1'b0, "R11 alert latency", 64'(alert), 64'h0);
    @(negedge clk);
    chk(alert == 1'b1, "R11 alert on write", 64'(alert), 64'h1);
    rd_reg(3'd0, d);
    chk(d[7] == 1'b1, "R6 mode alert bit", 64'(d[7]), 64'h1);
    chk(exc_req == 1'b0, "R10 no exc without enable", 64'(exc_req), 64'h0);

    // R9: sticky, then cleared by mode write
    evt_cyc = '0;
    repeat (3) @(negedge clk);
    chk(alert == 1'b1, "R9 sticky", 64'(alert), 64'h1);
    wr_reg(3'd0, M_CE1);
    chk(alert == 1'b0, "R9 cleared", 64'(alert), 64'h0);

    // R7: shared enable, unselected then frozen, then R6 armed
    wr_reg(3'd1, 64'h0);
    wr_reg(3'd0, M_CEN | M_FRZ_LOW);
    wr_reg(3'd2, 64'h8000_0000);
    repeat (2) @(negedge clk);
    chk(alert == 1'b0, "R7 select low", 64'(alert), 64'h0);
    evt_cyc[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk(alert == 1'b0, "R7 frozen", 64'(alert), 64'h0);
    wr_reg(3'd0, M_CE1);
    repeat (2) @(negedge clk);
    chk(alert == 1'b0, "R7 enable clear", 64'(alert), 64'h0);
    wr_reg(3'd0, M_CEN);
    @(negedge clk);
    chk(alert == 1'b1, "R6 shared enable", 64'(alert), 64'h1);

    // R8: counter 5 never alerts
    evt_cyc = '0;
    clear_all();
    wr_reg(3'd0, M_CEN);
    evt_cyc[4] = 1'b1;
    wr_reg(3'd5, 64'hC000_0000);
    repeat (3) @(negedge clk);
    chk(alert == 1'b0, "R8 counter 5", 64'(alert), 64'h0);

    // R10: exception pulse
    evt_cyc = '0;
    clear_all();
    wr_reg(3'd0, M_CE1 | M_EXC);
    evt_cyc[0] = 1'b1;
    wr_reg(3'd1, 64'h9000_0000);
    chk(exc_req == 1'b0, "R10 exc latency", 64'(exc_req), 64'h0);
    @(negedge clk);
    chk(exc_req == 1'b1 && alert == 1'b1, "R10 exc pulse", {exc_req, alert}, 64'h3);
    @(negedge clk);
    chk(exc_req == 1'b0, "R10 exc one cycle", 64'(exc_req), 64'h0);
    wr_reg(3'd0, M_CE1 | M_EXC);
    chk(alert == 1'b0, "R9 clear with condition held", 64'(alert), 64'h0);
    @(negedge clk);
    chk(alert == 1'b1 && exc_req == 1'b1, "R9 re-alert", {exc_req, alert}, 64'h3);

    // R12: counting across threshold
    evt_cyc = '0;
    clear_all();
    wr_reg(3'd1, 64'h7FFF_FFFE);
    wr_reg(3'd0, M_CE1);
    evt_cyc[0] = 1'b1;
    cnt_inc[0] = 1'b1;
    @(negedge clk);
    chk(alert == 1'b0, "R12 below threshold", 64'(alert), 64'h0);
    @(negedge clk);
    cnt_inc = '0;
    chk(alert == 1'b0, "R12 latency", 64'(alert), 64'h0);
    @(negedge clk);
    chk(alert == 1'b1, "R12 crossing alert", 64'(alert), 64'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule